// File: doc/BRIEF.md
# Wait-Stated ROM Read Sequencer

This block shares one read-only word store of 16K words by 16 bits among three read requesters. Port 0 serves instruction fetch, and ports 1 and 2 serve data reads. Each access is paced with wait states. The first word of a burst costs four cycles. Each later word of the same burst costs two cycles, as long as the same port asks for the next address without a pause. The store's contents are produced by a fixed arithmetic pattern, so no large array is built. A disable input turns the store off completely.

A requester raises its request line with a word address and holds both until its ready bit pulses. The returned word sits on the shared read-data bus during that ready cycle. During that same cycle the requester may drop its request. It may also keep it high with a new address. Doing so issues the next request at once, and a sequential address continues the burst.

Top module: `rom_wait_seq`

## Requirements
- R1: While reset is asserted and right after it, every ready bit is 0 and rdData is 0.
- R2: The word returned for address a is ((a * 40503) mod 65536) XOR 0x5A5A. It appears on rdData in the cycle where the port's ready bit is high.
- R3: A fresh access accepted at clock edge n raises ready at edge n+3, so the word is present in the fourth cycle after acceptance.
- R4: If the served port still requests during its ready cycle, and its address equals the previous address plus one (modulo 16K, so 0x3FFF is followed by 0x0000), the access is a continuation. Ready rises one edge after acceptance, so words arrive every two cycles.
- R5: A same-port request whose address is not sequential uses the fresh four-cycle timing. So does any request made after an idle cycle.
- R6: Among new requests, port 0 wins over port 1, and port 1 wins over port 2.
- R7: A port that still requests in its own ready cycle keeps the store. Other pending ports wait until it drops its request.
- R8: Ready is high for exactly one cycle, for at most one port, and never in two consecutive cycles.
- R9: While romOff is high, nothing is accepted and no ready is produced. An access in progress is dropped. A request still present after release restarts with the fresh timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| romOff | input | 1 | Disable: store ignores all requests while high |
| portReq | input | 3 | Request per port (bit 0 fetch, bits 1 and 2 data) |
| portAddr | input | 3 x 14 | Word address per port |
| portReady | output | 3 | One-cycle ready per port |
| rdData | output | 16 | Returned word, valid with a ready pulse |

## Verification
Assertions check the following on every cycle. Ready is one-hot and never back to back. Nothing is returned the cycle after the store is disabled. The wait counter stays within its first-word bound. A port that keeps requesting in its ready cycle retains the grant. The returned word and the held address change only on their strobes. The exact four- and two-cycle latencies, the priority order among simultaneous requests, and the address wrap in a burst are only visible in the bench's scenarios. The same holds for the returned data pattern and the restart after a disable in mid-access.

// File: rtl/romseq_pkg.sv
`timescale 1ns/1ps
package romseq_pkg;
  localparam int IDX_W = 2;

  typedef struct packed {
    logic             load;
    logic             capture;
    logic [IDX_W-1:0] portSel;
  } seqStrobe_t;
endpackage

// File: rtl/romseq_ctrl.sv
`timescale 1ns/1ps
module romseq_ctrl
  import romseq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int FIRST_LAT = 4,
  parameter int NEXT_LAT  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 romOff,
  input  logic [NUM_PORTS-1:0] portReq,
  input  logic [NUM_PORTS-1:0] seqHit,
  output seqStrobe_t           strobe,
  output logic [NUM_PORTS-1:0] portReady
);
  localparam int CNT_W = $clog2(FIRST_LAT + 1);

  logic             busyQ, doneQ;
  logic [CNT_W-1:0] cntQ, loadCnt;
  logic [IDX_W-1:0] grantQ, lastQ, prioSel, nextSel;
  logic             keepGrant, seqCont, accept, finish;

  initial begin
    assert (FIRST_LAT >= 2 && NEXT_LAT >= 2 && NEXT_LAT <= FIRST_LAT && NUM_PORTS <= 4);
  end

  // fixed priority: lowest index wins
  always_comb begin
    prioSel = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (portReq[i]) prioSel = IDX_W'(i);
    end
  end

  assign keepGrant = doneQ && portReq[lastQ];
  assign seqCont   = keepGrant && seqHit[lastQ];
  assign nextSel   = keepGrant ? lastQ : prioSel;
  assign accept    = !romOff && !busyQ && (|portReq);
  assign finish    = busyQ && (cntQ == CNT_W'(1));
  assign loadCnt   = seqCont ? CNT_W'(NEXT_LAT - 1) : CNT_W'(FIRST_LAT - 1);

  always_comb begin
    strobe.load    = accept;
    strobe.capture = finish && !romOff;
    strobe.portSel = accept ? nextSel : grantQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      cntQ   <= '0;
      grantQ <= '0;
      lastQ  <= '0;
    end else if (romOff) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= finish;
      if (accept) begin
        busyQ  <= 1'b1;
        cntQ   <= loadCnt;
        grantQ <= nextSel;
      end else if (finish) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
        lastQ <= grantQ;
      end else if (busyQ) begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      portReady[p] = doneQ && (lastQ == IDX_W'(p));
    end
  end

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portReady)); // R8
  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (|portReady) |=> !(|portReady)); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    romOff |=> !(|portReady)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cntQ >= CNT_W'(1) && cntQ <= CNT_W'(FIRST_LAT - 1))); // R3
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && portReq[lastQ] && !romOff) |=> (busyQ && grantQ == $past(lastQ))); // R7
endmodule

// File: rtl/romseq_dp.sv
`timescale 1ns/1ps
module romseq_dp
  import romseq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 16,
  parameter int PAT_MUL   = 40503,
  parameter int PAT_XOR   = 23130
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  seqStrobe_t                        strobe,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  portAddr,
  output logic [NUM_PORTS-1:0]              seqHit,
  output logic [DATA_W-1:0]                 rdData
);
  logic [ADDR_W-1:0] curAddrQ, lastAddrQ, nextAddr;
  logic [DATA_W-1:0] romWord, dataQ;

  // generated store content: one word per address
  always_comb begin
    romWord = (DATA_W'(curAddrQ) * DATA_W'(PAT_MUL)) ^ DATA_W'(PAT_XOR);
  end

  assign nextAddr = lastAddrQ + ADDR_W'(1);

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_seq
      assign seqHit[gp] = (portAddr[gp] == nextAddr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddrQ  <= '0;
      lastAddrQ <= '0;
      dataQ     <= '0;
    end else begin
      if (strobe.load) curAddrQ <= portAddr[strobe.portSel];
      if (strobe.capture) begin
        dataQ     <= romWord;
        lastAddrQ <= curAddrQ;
      end
    end
  end

  assign rdData = dataQ;

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(rdData)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(curAddrQ)); // R2
endmodule

// File: rtl/rom_wait_seq.sv
`timescale 1ns/1ps
module rom_wait_seq
  import romseq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 16,
  parameter int FIRST_LAT = 4,
  parameter int NEXT_LAT  = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             romOff,
  input  logic [NUM_PORTS-1:0]             portReq,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] portAddr,
  output logic [NUM_PORTS-1:0]             portReady,
  output logic [DATA_W-1:0]                rdData
);
  seqStrobe_t           strobe;
  logic [NUM_PORTS-1:0] seqHit;

  romseq_ctrl #(
    .NUM_PORTS(NUM_PORTS), .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .romOff(romOff), .portReq(portReq),
    .seqHit(seqHit), .strobe(strobe), .portReady(portReady)
  );

  romseq_dp #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .portAddr(portAddr),
    .seqHit(seqHit), .rdData(rdData)
  );
endmodule

// File: tb/test_rom_wait_seq.sv
`timescale 1ns/1ps
module test_rom_wait_seq;
  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            romOff = 1'b0;
  logic [2:0]      req = '0;
  logic [2:0][13:0] addr = '0;
  logic [2:0]      portReady;
  logic [15:0]     rdData;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rom_wait_seq i_rom_wait_seq (
    .clk(clk), .rstN(rstN), .romOff(romOff), .portReq(req),
    .portAddr(addr), .portReady(portReady), .rdData(rdData)
  );

  localparam int VEC_N = 12;
  localparam int vPort[VEC_N]  = '{0, 0, 0, 0, 1, 1, 2, 2, 1, 2, 0, 0};
  localparam int vAddr[VEC_N]  = '{256, 257, 258, 512, 291, 292, 16382, 16383, 292, 0, 16383, 0};
  localparam int vChain[VEC_N] = '{0, 1, 1, 1, 0, 1, 0, 1, 0, 0, 0, 1};
  localparam int vLat[VEC_N]   = '{4, 2, 2, 4, 4, 2, 4, 2, 4, 4, 4, 2};
  string vTag[VEC_N] = '{"R3", "R4", "R4", "R5", "R3", "R4", "R3", "R4", "R5", "R3", "R3", "R4"};

  function automatic logic [15:0] expWord(input int a);
    return 16'(((a * 40503) & 16'hFFFF) ^ 16'h5A5A);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitReady(input int p, input int expLat, input int a, input string tag);
    int n = 0;
    bit got = 0;
    while (n < 20 && !got) begin
      @(negedge clk);
      n++;
      if (portReady != 3'b000) got = 1;
    end
    check(got && portReady == 3'(1 << p), {tag, " ready port"}, int'(portReady), 1 << p);
    check(n == expLat, {tag, " latency"}, n, expLat);
    check(rdData == expWord(a), "R2 data", int'(rdData), int'(expWord(a)));
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (portReady != 3'b000) seen = 1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic idle();
    req = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(portReady == 3'b000, "R1 ready in reset", int'(portReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(portReady == 3'b000 && rdData == 16'h0, "R1 after reset", int'(rdData), 0);

    // table walk
    for (int v = 0; v < VEC_N; v++) begin
      if (vChain[v] == 0) idle();
      addr[vPort[v]] = 14'(vAddr[v]);
      req[vPort[v]] = 1'b1;
      waitReady(vPort[v], vLat[v], vAddr[v], vTag[v]);
    end
    idle();

    // R6: simultaneous requests resolve in priority order
    addr[0] = 14'd10; addr[1] = 14'd20; addr[2] = 14'd30;
    req = 3'b111;
    waitReady(0, 4, 10, "R6");
    req[0] = 1'b0;
    waitReady(1, 4, 20, "R6");
    req[1] = 1'b0;
    waitReady(2, 4, 30, "R6");
    idle();

    // R7: port 2 holds the store through a burst while port 1 waits
    addr[2] = 14'd100; addr[1] = 14'd50;
    req = 3'b100;
    @(negedge clk);
    req[1] = 1'b1;
    waitReady(2, 3, 100, "R7");
    addr[2] = 14'd101;
    waitReady(2, 2, 101, "R7");
    addr[2] = 14'd700;
    waitReady(2, 4, 700, "R7");
    req[2] = 1'b0;
    waitReady(1, 4, 50, "R7");
    idle();

    // R9: disabled store stays silent
    romOff = 1'b1;
    addr[0] = 14'd77;
    req[0] = 1'b1;
    quiet(10, "R9 silent while off");
    romOff = 1'b0;
    waitReady(0, 4, 77, "R9");
    idle();

    // R9: disable in mid-access drops it, then restarts fresh
    addr[1] = 14'd333;
    req[1] = 1'b1;
    repeat (2) @(negedge clk);
    romOff = 1'b1;
    quiet(1, "R9 abort");
    romOff = 1'b0;
    waitReady(1, 4, 333, "R9");
    idle();
    quiet(3, "R8 no stray ready");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule